// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block arbitrates interrupts for a small 8-bit processor core. Three event sources feed it: an active-low external pin, a timer overflow pulse and an analog conversion-done pulse. Each event latches a request flag in one 8-bit control register. The core reads and writes this register, and it also holds a per-source enable and a global enable.

Once per instruction cycle the core raises `phase_tick`. In that cycle the controller looks at the flags that are both pending and enabled. It may accept one of them only if the global enable is set and the core's return stack has a free level. On acceptance it gives a one-cycle acknowledge and a fixed vector address. In the same edge it clears the serviced flag and the global enable, so the service routine cannot be nested by default. A return-from-interrupt strobe from the core sets the global enable again. A request that is held off because the stack is full stays pending and is taken at a later tick.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and `irq_ack` is low.
- R2: A write through `reg_wr` loads bits 6:0 from `reg_wdata`. Register bit 7 always reads 0. Bit 0 is the global enable. Bits 1, 2 and 3 enable the pin, timer and converter sources. Bits 4, 5 and 6 are their request flags.
- R3: A high-to-low transition on `ext_irq_n` sets bit 4 on the third rising clock edge after the low level is applied, because the pin passes through two synchronising flops and an edge detector. A rising transition or a steady level sets nothing.
- R4: A one-cycle high on `tmr_ovf` sets bit 5 at the next edge. A one-cycle high on `conv_done` sets bit 6 at the next edge.
- R5: Request flags are recorded while their enable or the global enable is clear. They stay set until they are serviced or software writes them to 0.
- R6: `irq_ack` rises only after an edge at which `phase_tick` was high, the global enable was set, at least one flag was pending with its enable set, and `stack_full` was low. It is high for exactly one cycle.
- R7: When several enabled requests are pending, the pin wins over the timer, and the timer wins over the converter. `irq_vector` is 0x004 for the pin, 0x008 for the timer and 0x00C for the converter. It is valid while `irq_ack` is high.
- R8: On acknowledge, the serviced flag and the global enable are cleared. All other bits are kept.
- R9: While `stack_full` is high no acknowledge is given and the flag stays set. The request is taken at the first tick after `stack_full` falls.
- R10: A high on `reti_strobe` sets the global enable at the next edge. It takes precedence over a software write in the same cycle.
- R11: If a hardware event sets a flag in the same cycle as a software write or an acknowledge that would clear it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | 1 | External interrupt pin, asynchronous, falling edge active |
| tmr_ovf | input | 1 | Timer overflow event, one-cycle pulse |
| conv_done | input | 1 | Conversion complete event, one-cycle pulse |
| phase_tick | input | 1 | High for one cycle per instruction cycle, the sampling phase |
| stack_full | input | 1 | Return stack has no free level |
| reti_strobe | input | 1 | Core executed a return-from-interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| irq_ack | output | 1 | One-cycle acknowledge pulse |
| irq_vector | output | 12 | Vector address of the acknowledged source |

## Verification
The assertions assume that `tmr_ovf` and `conv_done` are clean synchronous pulses. They also assume that `phase_tick` is driven by the core and is not tied high. The acknowledge checks only look back one edge at `phase_tick`, the global enable and `stack_full`. The bench drives every input one time step after a rising edge and holds it for a whole cycle. It changes `ext_irq_n` only between checks, so no value depends on the order of updates at an edge. It uses single-cycle pulses on the event inputs and counts edges explicitly for the synchroniser latency.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int VEC_W    = 12,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_irq_n,
  input  logic             tmr_ovf,
  input  logic             conv_done,
  input  logic             phase_tick,
  input  logic             stack_full,
  input  logic             reti_strobe,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq_ack,
  output logic [VEC_W-1:0] irq_vector
);

  localparam logic [VEC_W-1:0] VEC_PIN  = VEC_W'(VEC_STEP);
  localparam logic [VEC_W-1:0] VEC_TMR  = VEC_W'(2 * VEC_STEP);
  localparam logic [VEC_W-1:0] VEC_CONV = VEC_W'(3 * VEC_STEP);

  logic [2:0] pin_q;
  logic [6:0] ctrl, ctrl_nx;
  logic [2:0] grant;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin_q <= 3'b111;
    else        pin_q <= {pin_q[1:0], ext_irq_n};

  wire       pin_fall = pin_q[2] & ~pin_q[1];
  wire [2:0] pend     = ctrl[6:4] & ctrl[3:1];
  wire       take     = phase_tick & ctrl[0] & (|pend) & ~stack_full;

  always_comb begin
    if      (pend[0]) grant = 3'b001;
    else if (pend[1]) grant = 3'b010;
    else if (pend[2]) grant = 3'b100;
    else              grant = 3'b000;
  end

  always_comb begin
    ctrl_nx = reg_wr ? reg_wdata[6:0] : ctrl;
    if (reti_strobe) ctrl_nx[0] = 1'b1;
    if (take) begin
      ctrl_nx[0]   = 1'b0;
      ctrl_nx[6:4] = ctrl_nx[6:4] & ~grant;
    end
    ctrl_nx[6:4] = ctrl_nx[6:4] | {conv_done, tmr_ovf, pin_fall};
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl       <= '0;
      irq_ack    <= 1'b0;
      irq_vector <= '0;
    end else begin
      ctrl    <= ctrl_nx;
      irq_ack <= take;
      if (take)
        irq_vector <= grant[0] ? VEC_PIN : (grant[1] ? VEC_TMR : VEC_CONV);
    end

  assign reg_rdata = {1'b0, ctrl};

  // R6 R9
  ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(phase_tick && !stack_full && ctrl[0]));

  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);

  // R7
  ack_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (irq_vector == VEC_PIN || irq_vector == VEC_TMR || irq_vector == VEC_CONV));

  // R7
  pin_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_vector != VEC_PIN) |-> !$past(pend[0]));

  // R8
  ack_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !reg_rdata[0]);

  // R5
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_rdata[5]) && !$past(reg_wr) && !irq_ack) |-> reg_rdata[5]);

  // R10
  reti_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reti_strobe) && !irq_ack) |-> reg_rdata[0]);

endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_irq_n = 1'b1, tmr_ovf = 1'b0, conv_done = 1'b0;
  logic phase_tick = 1'b0, stack_full = 1'b0, reti_strobe = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq_ack;
  logic [11:0] irq_vector;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .tmr_ovf(tmr_ovf),
    .conv_done(conv_done), .phase_tick(phase_tick), .stack_full(stack_full),
    .reti_strobe(reti_strobe), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq_vector(irq_vector));

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d; step(); reg_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reg", reg_rdata, 8'h00);
    check("R1 ack", irq_ack, 0);
  endtask

  task automatic t_regs();
    wr(8'hFF); check("R2 bit7 zero", reg_rdata, 8'h7F);
    wr(8'h5A); check("R2 pattern", reg_rdata, 8'h5A);
    wr(8'h00); check("R2 clear", reg_rdata, 8'h00);
  endtask

  task automatic t_pin();
    ext_irq_n = 1'b0;
    step(); step();
    check("R3 not yet", reg_rdata[4], 0);
    step();
    check("R3 fall sets", reg_rdata[4], 1);
    wr(8'h00);
    ext_irq_n = 1'b1;
    for (int i = 0; i < 5; i++) step();
    check("R3 rise ignored", reg_rdata[4], 0);
  endtask

  task automatic t_events();
    tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0;
    check("R4 timer flag", reg_rdata, 8'h20);
    conv_done = 1'b1; step(); conv_done = 1'b0;
    check("R4 conv flag", reg_rdata, 8'h60);
    phase_tick = 1'b1; step(); phase_tick = 1'b0;
    check("R5 masked no ack", irq_ack, 0);
    check("R5 flags kept", reg_rdata, 8'h60);
    wr(8'h00);
  endtask

  task automatic t_priority();
    wr(8'h7F);
    phase_tick = 1'b1; step(); phase_tick = 1'b0;
    check("R6 ack", irq_ack, 1);
    check("R7 pin vector", irq_vector, 12'h004);
    check("R8 clear pin+gie", reg_rdata, 8'h6E);
    step();
    check("R6 one cycle", irq_ack, 0);
    reti_strobe = 1'b1; step(); reti_strobe = 1'b0;
    check("R10 reti", reg_rdata, 8'h6F);
    phase_tick = 1'b1; step(); phase_tick = 1'b0;
    check("R7 timer vector", irq_vector, 12'h008);
    check("R8 clear timer", reg_rdata, 8'h4E);
    reti_strobe = 1'b1; step(); reti_strobe = 1'b0;
    phase_tick = 1'b1; step(); phase_tick = 1'b0;
    check("R7 conv vector", irq_vector, 12'h00C);
    check("R8 clear conv", reg_rdata, 8'h0E);
  endtask

  task automatic t_gating();
    wr(8'h25);
    step();
    check("R6 no tick no ack", irq_ack, 0);
    stack_full = 1'b1; phase_tick = 1'b1; step();
    check("R9 held off", irq_ack, 0);
    check("R9 flag kept", reg_rdata, 8'h25);
    stack_full = 1'b0; step(); phase_tick = 1'b0;
    check("R9 served", irq_ack, 1);
    check("R9 vector", irq_vector, 12'h008);
    check("R9 state", reg_rdata, 8'h04);
    reti_strobe = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h00; step();
    reti_strobe = 1'b0; reg_wr = 1'b0;
    check("R10 over write", reg_rdata, 8'h01);
  endtask

  task automatic t_collide();
    tmr_ovf = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h00; step();
    tmr_ovf = 1'b0; reg_wr = 1'b0;
    check("R11 set beats write", reg_rdata, 8'h20);
    wr(8'h25);
    tmr_ovf = 1'b1; phase_tick = 1'b1; step();
    tmr_ovf = 1'b0; phase_tick = 1'b0;
    check("R11 ack taken", irq_ack, 1);
    check("R11 set beats ack", reg_rdata, 8'h24);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    #20 rst_n = 1'b1;
    step();
    t_reset();
    t_regs();
    t_pin();
    t_events();
    t_priority();
    t_gating();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule